// File: doc/BRIEF.md
# Gray-Coded Delay-Line Phase Sequencer

This block moves a sampling delay line to a new output phase. A requester hands it a 4-bit phase number (0 to 15). The block then steps the delay-line configuration word through a fixed series of read-modify-write updates:

- It gates the output clock off and holds the recovery loop in external-select mode.
- It waits for the clock-output status to drop.
- It writes the phase as a 4-bit Gray code.
- It gates the clock back on and waits for the status to rise.
- It hands control back to the recovery loop.

Each of the two status waits is bounded by a cycle timer. An expired wait ends the sequence with an error pulse. A clean finish gives a done pulse.

The configuration register sits outside the block:

- Its current value arrives on `cfg_rdata`.
- The block writes a new value by raising `cfg_we` with `cfg_wdata` for one cycle. Each write is built from the value read in that same cycle, so fields the block does not own pass through unchanged.

The request port is valid/ready:

- A phase is taken on a cycle where `req_valid` and `req_ready` are both high.
- `req_ready` is high only while the block is idle.
- A request offered while a sequence runs is not queued or held. It is dropped, and the requester must offer it again once `req_ready` returns.

Top module: `dl_phase_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `cfg_we` are low and `req_ready` is high.
- R2: The phase is written into bits 23:20 of the configuration word as a Gray code: phases 0..15 map to 0,1,3,2,6,7,5,4,C,D,F,E,A,B,9,8.
- R3: The first write of a sequence, in the cycle after acceptance, clears recovery enable (bit 17) and clock-output enable (bit 18) and sets delay-line enable (bit 16) and external-select enable (bit 19).
- R4: The write of the select field happens only after `ckout_stat` has been seen low, and it changes nothing but bits 23:20.
- R5: The next write sets bit 18. The final write happens only after `ckout_stat` has been seen high.
- R6: The final write sets bit 17 and clears bit 19. A successful sequence makes exactly four writes and ends with a one-cycle `done` pulse.
- R7: Each status wait lasts at most TIMEOUT_CYC cycles. On expiry the block pulses `err`, returns to idle and makes no further write. `busy` is high for 1+TIMEOUT_CYC cycles when the status never drops, and for 4+TIMEOUT_CYC cycles when it never rises.
- R8: `req_ready` is low while `busy` is high. A request offered then has no effect on the written phase and does not start another sequence.
- R9: Every write keeps all configuration bits outside 16..23 at their read values.
- R10: `done` and `err` never pulse together. In the cycle where `busy` falls, exactly one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Phase request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_phase | input | 4 | Requested phase, 0..15 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: sequence completed |
| err | output | 1 | One-cycle pulse: status wait timed out |
| cfg_rdata | input | 32 | Current configuration word |
| cfg_we | output | 1 | Write strobe for the configuration word |
| cfg_wdata | output | 32 | New configuration word |
| ckout_stat | input | 1 | Read-back of clock-output enable from the delay line |

## Verification
Some properties are checked every cycle against the live ports:

- the content of the gate-off write;
- that bits outside the owned fields survive every write;
- that no write occurs outside a sequence or alongside an error;
- that each sequence end carries exactly one result pulse.

Other behaviour only the bench scenarios can show:

- the Gray value chosen for every phase;
- that writes wait on the delayed status;
- the exact length of each timeout;
- that a request made during a run is dropped.

For these, the bench uses a register model with a lagging status and stuck-status cases.

// File: rtl/dl_phase_seq_pkg.sv
package dl_phase_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_GATEOFF, ST_WAITLO, ST_SEL, ST_GATEON, ST_WAITHI, ST_HAND
  } seq_state_t;

  typedef enum logic [1:0] {
    OP_GATEOFF, OP_SEL, OP_GATEON, OP_HAND
  } wr_op_t;
endpackage

// File: rtl/dl_phase_seq_gray.sv
module dl_phase_seq_gray #(
  parameter int W = 4
) (
  input  logic [W-1:0] bin,
  output logic [W-1:0] code
);
  genvar i;
  generate
    for (i = 0; i < W - 1; i++) begin : g_bit
      assign code[i] = bin[i] ^ bin[i+1];
    end
  endgenerate
  assign code[W-1] = bin[W-1];
endmodule

// File: rtl/dl_phase_seq_timer.sv
module dl_phase_seq_timer #(
  parameter int LIMIT = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic dec,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] START = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= START;
    else if (dec && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/dl_phase_seq_word.sv
module dl_phase_seq_word
  import dl_phase_seq_pkg::*;
#(
  parameter int W          = 32,
  parameter int DLL_EN_BIT = 16,
  parameter int CDR_EN_BIT = 17,
  parameter int CKOUT_BIT  = 18,
  parameter int EXTSEL_BIT = 19,
  parameter int SEL_LSB    = 20,
  parameter int SEL_W      = 4
) (
  input  wr_op_t           op,
  input  logic [SEL_W-1:0] sel_code,
  input  logic [W-1:0]     rdata,
  output logic [W-1:0]     wdata
);
  always_comb begin
    wdata = rdata;
    unique case (op)
      OP_GATEOFF: begin
        wdata[CDR_EN_BIT] = 1'b0;
        wdata[CKOUT_BIT]  = 1'b0;
        wdata[EXTSEL_BIT] = 1'b1;
        wdata[DLL_EN_BIT] = 1'b1;
      end
      OP_SEL:    wdata[SEL_LSB +: SEL_W] = sel_code;
      OP_GATEON: wdata[CKOUT_BIT] = 1'b1;
      OP_HAND: begin
        wdata[CDR_EN_BIT] = 1'b1;
        wdata[EXTSEL_BIT] = 1'b0;
      end
      default: wdata = rdata;
    endcase
  end
endmodule

// File: rtl/dl_phase_seq_ctrl.sv
module dl_phase_seq_ctrl
  import dl_phase_seq_pkg::*;
#(
  parameter int PH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [PH_W-1:0] req_phase,
  input  logic            stat,
  input  logic            tmr_expired,
  output logic            req_ready,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic            we,
  output wr_op_t          op,
  output logic            tmr_load,
  output logic            tmr_dec,
  output logic [PH_W-1:0] phase_q
);
  seq_state_t state, state_n;
  logic done_set, err_set;

  always_comb begin
    state_n  = state;
    we       = 1'b0;
    op       = OP_GATEOFF;
    tmr_load = 1'b0;
    tmr_dec  = 1'b0;
    done_set = 1'b0;
    err_set  = 1'b0;
    unique case (state)
      ST_IDLE:    if (req_valid) state_n = ST_GATEOFF;
      ST_GATEOFF: begin
        we = 1'b1; op = OP_GATEOFF; tmr_load = 1'b1;
        state_n = ST_WAITLO;
      end
      ST_WAITLO: begin
        if (!stat)            state_n = ST_SEL;
        else if (tmr_expired) begin state_n = ST_IDLE; err_set = 1'b1; end
        else                  tmr_dec = 1'b1;
      end
      ST_SEL: begin
        we = 1'b1; op = OP_SEL;
        state_n = ST_GATEON;
      end
      ST_GATEON: begin
        we = 1'b1; op = OP_GATEON; tmr_load = 1'b1;
        state_n = ST_WAITHI;
      end
      ST_WAITHI: begin
        if (stat)             state_n = ST_HAND;
        else if (tmr_expired) begin state_n = ST_IDLE; err_set = 1'b1; end
        else                  tmr_dec = 1'b1;
      end
      ST_HAND: begin
        we = 1'b1; op = OP_HAND; done_set = 1'b1;
        state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      phase_q <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      state <= state_n;
      done  <= done_set;
      err   <= err_set;
      if (state == ST_IDLE && req_valid) phase_q <= req_phase;
    end
  end

  assign busy      = (state != ST_IDLE);
  assign req_ready = (state == ST_IDLE);
endmodule

// File: rtl/dl_phase_seq.sv
module dl_phase_seq
  import dl_phase_seq_pkg::*;
#(
  parameter int W           = 32,
  parameter int PH_W        = 4,
  parameter int SEL_LSB     = 20,
  parameter int DLL_EN_BIT  = 16,
  parameter int CDR_EN_BIT  = 17,
  parameter int CKOUT_BIT   = 18,
  parameter int EXTSEL_BIT  = 19,
  parameter int TIMEOUT_CYC = 2500
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [PH_W-1:0] req_phase,
  output logic            busy,
  output logic            done,
  output logic            err,
  input  logic [W-1:0]    cfg_rdata,
  output logic            cfg_we,
  output logic [W-1:0]    cfg_wdata,
  input  logic            ckout_stat
);
  wr_op_t          op;
  logic            tmr_load, tmr_dec, tmr_expired;
  logic [PH_W-1:0] phase_q, gray_code;

  dl_phase_seq_ctrl #(.PH_W(PH_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_phase(req_phase),
    .stat(ckout_stat), .tmr_expired(tmr_expired), .req_ready(req_ready),
    .busy(busy), .done(done), .err(err), .we(cfg_we), .op(op),
    .tmr_load(tmr_load), .tmr_dec(tmr_dec), .phase_q(phase_q)
  );

  dl_phase_seq_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .dec(tmr_dec),
    .expired(tmr_expired)
  );

  dl_phase_seq_gray #(.W(PH_W)) u_gray (.bin(phase_q), .code(gray_code));

  dl_phase_seq_word #(
    .W(W), .DLL_EN_BIT(DLL_EN_BIT), .CDR_EN_BIT(CDR_EN_BIT),
    .CKOUT_BIT(CKOUT_BIT), .EXTSEL_BIT(EXTSEL_BIT),
    .SEL_LSB(SEL_LSB), .SEL_W(PH_W)
  ) u_word (
    .op(op), .sel_code(gray_code), .rdata(cfg_rdata), .wdata(cfg_wdata)
  );
endmodule

// File: rtl/dl_phase_seq_chk.sv
module dl_phase_seq_chk #(
  parameter int W          = 32,
  parameter int PH_W       = 4,
  parameter int SEL_LSB    = 20,
  parameter int DLL_EN_BIT = 16,
  parameter int CDR_EN_BIT = 17,
  parameter int CKOUT_BIT  = 18,
  parameter int EXTSEL_BIT = 19
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         done,
  input logic         err,
  input logic         cfg_we,
  input logic [W-1:0] cfg_wdata,
  input logic [W-1:0] cfg_rdata
);
  localparam logic [W-1:0] OWNED =
    ({{(W-PH_W){1'b0}}, {PH_W{1'b1}}} << SEL_LSB) |
    (W'(1) << DLL_EN_BIT) | (W'(1) << CDR_EN_BIT) |
    (W'(1) << CKOUT_BIT)  | (W'(1) << EXTSEL_BIT);

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)); // R10
  AST_END_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || err)); // R10
  AST_GATEOFF_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cfg_we && cfg_wdata[DLL_EN_BIT] && cfg_wdata[EXTSEL_BIT]
                     && !cfg_wdata[CDR_EN_BIT] && !cfg_wdata[CKOUT_BIT])); // R3
  AST_KEEP_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> ((cfg_wdata & ~OWNED) == (cfg_rdata & ~OWNED))); // R9
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (err || !busy) |-> !cfg_we); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
endmodule

bind dl_phase_seq dl_phase_seq_chk #(
  .W(W), .PH_W(PH_W), .SEL_LSB(SEL_LSB), .DLL_EN_BIT(DLL_EN_BIT),
  .CDR_EN_BIT(CDR_EN_BIT), .CKOUT_BIT(CKOUT_BIT), .EXTSEL_BIT(EXTSEL_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
);

// File: tb/sim_dl_phase_seq.sv
module sim_dl_phase_seq;
  localparam int T = 20;
  localparam int LAT = 3;

  typedef struct {
    bit          ok;
    logic [31:0] word;
    int          writes;
    int          busy_cyc;
    logic [3:0]  gray;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, busy, done, err, cfg_we, ckout_stat;
  logic [3:0] req_phase = 0;
  logic [31:0] cfg_q, cfg_wdata, preload_val = 0;
  logic preload_en = 0, force_en = 0, force_val = 0;
  logic [LAT-1:0] pipe;

  int checks = 0, errors = 0, wr_cnt = 0, busy_cnt = 0;
  item_t q[$];

  localparam logic [3:0] GRAY [16] = '{4'h0, 4'h1, 4'h3, 4'h2, 4'h6, 4'h7,
    4'h5, 4'h4, 4'hC, 4'hD, 4'hF, 4'hE, 4'hA, 4'hB, 4'h9, 4'h8};

  always #10 clk = ~clk;

  dl_phase_seq #(.TIMEOUT_CYC(T)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_phase(req_phase), .busy(busy), .done(done), .err(err),
    .cfg_rdata(cfg_q), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ckout_stat(ckout_stat)
  );

  always_ff @(posedge clk) begin
    if (preload_en)  cfg_q <= preload_val;
    else if (cfg_we) cfg_q <= cfg_wdata;
    pipe <= {pipe[LAT-2:0], cfg_q[18]};
  end
  assign ckout_stat = force_en ? force_val : pipe[LAT-1];

  task automatic chk(input bit c, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected results and checks writes as they happen
  always @(negedge clk) begin
    if (rst_n) begin
      if ((done || err) && q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk(!(done && err), "R10 single result", {done, err}, 2'b10);
        chk(done == it.ok, "R6/R7 result kind", done, it.ok);
        chk(cfg_q == it.word, "R2/R9 final word", cfg_q, it.word);
        chk(wr_cnt == it.writes, "R6/R7 write count", wr_cnt, it.writes);
        if (it.busy_cyc != 0)
          chk(busy_cnt == it.busy_cyc, "R7 timeout length", busy_cnt, it.busy_cyc);
        wr_cnt = 0;
        busy_cnt = 0;
      end
      if (busy) busy_cnt++;
      if (cfg_we && q.size() > 0) begin
        if (wr_cnt == 0)
          chk(cfg_wdata[19:16] == 4'b1001, "R3 gate-off bits", cfg_wdata[19:16], 4'b1001);
        if (wr_cnt == 1) begin
          chk(ckout_stat == 1'b0, "R4 status low before select", ckout_stat, 0);
          chk(cfg_wdata[23:20] == q[0].gray, "R4 select code", cfg_wdata[23:20], q[0].gray);
        end
        if (wr_cnt == 2)
          chk(cfg_wdata[18] == 1'b1, "R5 gate-on bit", cfg_wdata[18], 1);
        if (wr_cnt == 3) begin
          chk(ckout_stat == 1'b1, "R5 status high before handover", ckout_stat, 1);
          chk(cfg_wdata[19:17] == 3'b011, "R6 handover bits", cfg_wdata[19:17], 3'b011);
        end
        wr_cnt++;
      end
    end
  end

  // mode 0: normal, 1: status stuck high, 2: status stuck low
  task automatic run_seq(input int ph, input logic [31:0] init, input int mode,
                         input bit poke);
    item_t it;
    logic [3:0] g;
    g = GRAY[ph];
    @(negedge clk);
    preload_val = init; preload_en = 1;
    force_en = (mode != 0); force_val = (mode == 1);
    @(negedge clk);
    preload_en = 0;
    repeat (LAT + 2) @(negedge clk);
    it.gray = g;
    if (mode == 0) begin
      it.ok = 1; it.writes = 4; it.busy_cyc = 0;
      it.word = (init & ~32'h00FF_0000) | {8'h0, g, 4'b0111, 16'h0};
    end else if (mode == 1) begin
      it.ok = 0; it.writes = 1; it.busy_cyc = 1 + T;
      it.word = (init & ~32'h000F_0000) | 32'h0009_0000;
    end else begin
      it.ok = 0; it.writes = 3; it.busy_cyc = 4 + T;
      it.word = (init & ~32'h00FF_0000) | {8'h0, g, 4'b1101, 16'h0};
    end
    q.push_back(it);
    chk(req_ready == 1'b1, "R8 ready when idle", req_ready, 1);
    req_valid = 1; req_phase = 4'(ph);
    @(negedge clk);
    req_valid = 0;
    if (poke) begin
      @(negedge clk);
      chk(req_ready == 1'b0, "R8 ready low while busy", req_ready, 0);
      req_valid = 1; req_phase = 4'(ph) ^ 4'h5;
      @(negedge clk);
      req_valid = 0;
    end
    while (!(done || err)) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(busy == 1'b0, "R8 no extra sequence", busy, 0);
    end
    force_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0, "R1 busy after reset", busy, 0);
    chk(done == 0 && err == 0, "R1 pulses after reset", {done, err}, 0);
    chk(cfg_we == 0, "R1 no write after reset", cfg_we, 0);
    chk(req_ready == 1, "R1 ready after reset", req_ready, 1);
    rst_n = 1;
    for (int p = 0; p < 16; p++)
      run_seq(p, 32'hA5A5_0F0F ^ (32'(p) * 32'h0101_0101) ^ (p[0] ? 32'h0004_0000 : 0), 0, p == 5);
    run_seq(9, 32'h1234_5678 | 32'h0004_0000, 1, 0);
    run_seq(6, 32'hFFFF_FFFF, 2, 0);
    run_seq(12, 32'h0000_0000, 0, 1);
    chk(q.size() == 0, "R10 all results seen", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule